// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block holds the control and register logic for an N-bit successive-approximation analog-to-digital converter. An external digital-to-analog converter turns the block's trial code into a voltage, and an external comparator reports whether the analog input lies above it. The block runs a binary search across the code bits, from the most significant to the least significant. It decides one bit per clock and delivers the converged code on its result port, along with a completion flag.

A start pulse is accepted only when no conversion is running. This covers both the idle state that follows reset and the finished state. After the start pulse, the controller spends one cycle clearing its working register. It then spends N cycles deciding bits, so every conversion lasts exactly N+1 clocks. The controller is built around four named states:

- `ST_IDLE` is the post-reset state. It moves to `ST_CLEAR` on a start pulse.
- `ST_CLEAR` is the clear cycle. It always moves to `ST_TRIAL`.
- `ST_TRIAL` repeats once per bit. It moves to `ST_DONE` after the least significant decision.
- `ST_DONE` raises the completion flag. It moves to `ST_CLEAR` on a start pulse.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `eoc_o` is low, `result_o` is all zeros and `trial_o` is all zeros.
- R2: `soc_i` sampled high at a clock edge in `ST_IDLE` or `ST_DONE` begins a conversion. The following cycle is the clear cycle, in which `trial_o` is zero and `eoc_o` is low.
- R3: The first trial code after the clear cycle has only the most significant bit (bit N-1) set.
- R4: In each trial, `trial_o` carries the bits already decided above the bit under test, then a 1 at the bit under test, then zeros below it.
- R5: `cmp_i` is sampled at the clock edge that ends each trial cycle. High keeps the tested bit at 1, low clears it to 0, and the next trial then tests the next lower bit. One bit is decided per clock.
- R6: `eoc_o` rises at the (N+1)th clock edge after the edge that accepted `soc_i`.
- R7: `result_o` equals the code found by the search. For a stationary input, this is the largest code whose level lies below the input, with all ones for an input above full scale. `result_o` and a high `eoc_o` stay unchanged until a new start is accepted.
- R8: `trial_o` is all zeros whenever no trial is in progress (idle, clear and done).
- R9: `soc_i` during the clear cycle or any trial cycle, including the cycle of the least significant decision, is ignored. Timing and result are unchanged.
- R10: A start accepted while `eoc_o` is high drops `eoc_o` in the next cycle. The previous `result_o` stays visible until the new conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soc_i | input | 1 | Start-of-conversion request, sampled on the rising edge |
| cmp_i | input | 1 | Comparator output, high when the analog input exceeds the trial level |
| trial_o | output | N | Trial code sent to the external converter |
| result_o | output | N | Last completed conversion result |
| eoc_o | output | 1 | End-of-conversion flag |

## Verification
A start request can coincide with a conversion step. The sharpest collision is a start pulse held during the cycle whose closing edge makes the least significant decision and raises `eoc_o`. The bench provokes this by placing one-cycle start pulses in the clear cycle, in a middle trial and in that final trial. It then checks that each trial code, the completion edge and the result match an undisturbed search on the same input. A second collision is a start arriving while `eoc_o` is high. It is judged by seeing `eoc_o` fall one cycle later while the old result stays on the port until the new one lands.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_TRIAL = 2'd2,
        ST_DONE  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             soc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             clr_o,
    output logic             dec_o,
    output logic             last_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);

    sar_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (soc_i) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_TRIAL;
            ST_TRIAL: if (idx_q == '0) state_d = ST_DONE;
            ST_DONE:  if (soc_i) state_d = ST_CLEAR;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and bit pointer
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                idx_q <= TOP_IDX;
            end else if (state_q == ST_TRIAL && idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    // decoded controls
    always_comb begin
        clr_o  = (state_q == ST_CLEAR);
        dec_o  = (state_q == ST_TRIAL);
        last_o = (state_q == ST_TRIAL) && (idx_q == '0);
        done_o = (state_q == ST_DONE);
        idx_o  = idx_q;
    end

    AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRIAL) |=> (state_q != ST_CLEAR)); // R9

    AST_PTR_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRIAL && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1)); // R5

endmodule

// File: rtl/sar_mask.sv
module sar_mask #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             en_i,
    output logic [N-1:0]     mask_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign mask_o[i] = en_i && (idx_i == IDX_W'(i));
    end

    always_comb begin
        AST_ONE_TRIAL_BIT: assert (!en_i || $countones(mask_o) == 1); // R4
    end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         dec_i,
    input  logic         last_i,
    input  logic [N-1:0] mask_i,
    input  logic         cmp_i,
    output logic [N-1:0] trial_o,
    output logic [N-1:0] result_o
);

    logic [N-1:0] acc_q;
    logic [N-1:0] res_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
        end else if (dec_i) begin
            if (last_i) begin
                res_q <= cmp_i ? (acc_q | mask_i) : acc_q;
                acc_q <= '0;
            end else if (cmp_i) begin
                acc_q <= acc_q | mask_i;
            end
        end
    end

    always_comb begin
        trial_o  = acc_q | mask_i;
        result_o = res_q;
    end

    AST_BIT_DECIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i && !last_i) |=>
        ((trial_o & $past(mask_i)) == ($past(cmp_i) ? $past(mask_i) : '0))); // R5

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         soc_i,
    input  logic         cmp_i,
    output logic [N-1:0] trial_o,
    output logic [N-1:0] result_o,
    output logic         eoc_o
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int CNT_W = $clog2(N + 2) + 1;
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic [IDX_W-1:0] idx;
    logic             clr, dec, last, done;
    logic [N-1:0]     mask;

    sar_seq #(.N(N), .IDX_W(IDX_W)) u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .soc_i  (soc_i),
        .idx_o  (idx),
        .clr_o  (clr),
        .dec_o  (dec),
        .last_o (last),
        .done_o (done)
    );

    sar_mask #(.N(N), .IDX_W(IDX_W)) u_mask (
        .idx_i  (idx),
        .en_i   (dec),
        .mask_o (mask)
    );

    sar_datapath #(.N(N)) u_dp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .dec_i    (dec),
        .last_i   (last),
        .mask_i   (mask),
        .cmp_i    (cmp_i),
        .trial_o  (trial_o),
        .result_o (result_o)
    );

    assign eoc_o = done;

    // cycle counter for the conversion-length check
    logic [CNT_W-1:0] chk_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  chk_cnt <= '0;
        else if (clr) chk_cnt <= CNT_W'(1);
        else if (dec) chk_cnt <= chk_cnt + 1'b1;
    end

    AST_FIRST_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr |=> (trial_o == MSB_ONLY)); // R3

    AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eoc_o) |-> (chk_cnt == CNT_W'(N + 1))); // R6

    AST_EOC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoc_o && !soc_i) |=> (eoc_o && $stable(result_o))); // R7

    AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoc_o || clr) |-> (trial_o == '0)); // R8

    AST_EOC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoc_o && soc_i) |=> (!eoc_o && $stable(result_o))); // R10

endmodule

// File: tb/tb_sar_ctrl.sv
module tb_sar_ctrl;

    localparam int N = 8;
    localparam int FULL = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soc = 1'b0;
    logic         cmp;
    logic [N-1:0] trial;
    logic [N-1:0] result;
    logic         eoc;

    int vin_half = 0;   // analog input in half-LSB units
    int n_checks = 0;
    int n_fail   = 0;
    int prev_res = 0;
    int exp_q[$];
    bit done_all = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    // behavioural DAC + comparator
    always_comb cmp = (vin_half > 2 * int'(trial));

    sar_ctrl #(.N(N)) dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .soc_i    (soc),
        .cmp_i    (cmp),
        .trial_o  (trial),
        .result_o (result),
        .eoc_o    (eoc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: vh = input in half-LSB units, ev = expected code,
    // inj = trial step carrying a stray start (-1: clear cycle, N: none)
    task automatic convert(input int vh, input int ev, input int inj);
        vin_half = vh;
        exp_q.push_back(ev);
        @(negedge clk);
        soc = 1'b1;
        @(negedge clk);                       // clear cycle
        soc = (inj == -1);
        check(trial == 0, "R2 clear trial", int'(trial), 0);
        check(eoc == 1'b0, "R2/R10 eoc low", int'(eoc), 0);
        check(int'(result) == prev_res, "R10 old result held", int'(result), prev_res);
        for (int k = 0; k < N; k++) begin
            int b, et;
            @(negedge clk);
            soc = (inj == k);
            b  = N - 1 - k;
            et = ((ev >> (b + 1)) << (b + 1)) | (1 << b);
            if (k == 0) check(int'(trial) == (1 << (N - 1)), "R3 first trial", int'(trial), 1 << (N - 1));
            else        check(int'(trial) == et, "R4 trial code", int'(trial), et);
            check(eoc == 1'b0, "R6 eoc not early", int'(eoc), 0);
        end
        @(negedge clk);
        soc = 1'b0;
        check(eoc == 1'b1, "R6 eoc at N+1", int'(eoc), 1);
        check(trial == 0, "R8 trial zero when done", int'(trial), 0);
        if (inj != N) check(int'(result) == ev, "R9 stray start ignored", int'(result), ev);
        prev_res = ev;
        // hold window with input moved away
        vin_half = 3;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            check(eoc == 1'b1 && int'(result) == ev, "R7 hold", int'(result), ev);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge eoc);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected eoc", int'(result), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(result) == e, "R7 result", int'(result), e);
            end
        end
    end

    // watchdog
    initial begin
        #(5 * 50000);
        if (!done_all) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(eoc == 1'b0, "R1 eoc", int'(eoc), 0);
        check(result == 0, "R1 result", int'(result), 0);
        check(trial == 0, "R1/R8 trial", int'(trial), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(trial == 0 && eoc == 1'b0, "R8 idle", int'(trial), 0);

        convert(2 * 170 + 1, 170, N);   // from idle, R5 alternating bits
        convert(2 * 85 + 1, 85, N);     // from done
        convert(1, 0, N);               // bottom code
        convert(2 * FULL + 1, FULL, N); // top code
        convert(2 * 300, FULL, N);      // above full scale
        convert(2 * 128 + 1, 128, N);
        convert(2 * 127 + 1, 127, N);
        convert(2 * 1 + 1, 1, N);
        convert(2 * 100 + 1, 100, 3);   // R9 start mid-search
        convert(2 * 60 + 1, 60, -1);    // R9 start during clear
        convert(2 * 201 + 1, 201, N - 1); // R9 start on LSB decision

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        done_all = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule